// File: doc/BRIEF.md
# Synchronous Burst SRAM Core

This block is a single-ported static memory with a two-bit burst address generator, for use as a fast local buffer behind a processor or a cache controller. Address, chip enables, strobes, write controls and write data are all captured on the rising clock edge. Read data is not registered on the way out: it comes from the array through the registered address in the same cycle that address was sampled, and it is gated onto the bus by an asynchronous output enable.

Either of two address strobes can open a burst. The processor strobe always opens a read and is honoured only while the primary enable is asserted. The controller strobe opens a read or a write according to the write controls. With both strobes idle, the advance input either steps the burst to its next address or holds it at the current one. The step order is set by a mode input: it either adds to the two low address bits or XORs them. A snooze input freezes the block in place and releases the bus.

Top module: `sync_burst_sram`

## Requirements
- R1: While `snooze_i` is low, a cycle with `en_main_ni` high and `ctrl_stb_ni` low deselects the block, writes nothing, and leaves `drive_o` low after that edge, until a later burst start.
- R2: While `snooze_i` is low, a cycle with `en_main_ni` low and either `en_hi_i` low or `en_lo_ni` high deselects the block if either strobe is low. It writes nothing, and `drive_o` is low after the edge.
- R3: With all three enables active (`en_main_ni`=0, `en_hi_i`=1, `en_lo_ni`=0) and `proc_stb_ni` low, a burst starts at `addr_i` as a read. This holds even when the write controls request a write, and the array is left unchanged.
- R4: With all enables active, `proc_stb_ni` high and `ctrl_stb_ni` low, a burst starts at `addr_i`. It is a write if `gw_ni` or `bwe_ni` is low, and a read otherwise.
- R5: With both strobes high (or the processor strobe ignored under R7) and `adv_ni` low, the burst moves on by one step from its start address b. After n steps the low two bits are (b+n) mod 4 when `ilv_i`=0, and b XOR n when `ilv_i`=1. The upper address bits do not change.
- R6: With both strobes high and `adv_ni` high, the burst stays at its current address. On a read, `data_o` is unchanged.
- R7: With `en_main_ni` high, a low `proc_stb_ni` is ignored. If `ctrl_stb_ni` is high as well, the cycle is a continue or suspend cycle decided by `adv_ni`.
- R8: On a write cycle, a low `gw_ni` writes all four lanes. Otherwise a low `bwe_ni` writes each lane i whose `bsel_ni[i]` is low. Lane i is `data_i[9*i+8:9*i]`.
- R9: With `gw_ni` and `bwe_ni` both high, a cycle is a read and the array is not changed.
- R10: `drive_o` is high only when the block is selected, the current cycle is a read, `oe_ni` is low and `snooze_i` is low. It is low after every write cycle. `data_o` is zero while `drive_o` is low.
- R11: Read data is flow-through. `data_o` shows the word at the address sampled on the latest edge during that same cycle, and it follows `oe_ni` with no clock edge.
- R12: While `snooze_i` is high, all synchronous inputs are ignored, burst state and array contents are kept, and `drive_o` is low. When snooze is released, the read resumes at the held address.
- R13: After reset the block is deselected and `drive_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | AW | External word address |
| proc_stb_ni | input | 1 | Processor address strobe, active low |
| ctrl_stb_ni | input | 1 | Controller address strobe, active low |
| en_main_ni | input | 1 | Primary chip enable, active low |
| en_hi_i | input | 1 | Secondary chip enable, active high |
| en_lo_ni | input | 1 | Secondary chip enable, active low |
| adv_ni | input | 1 | Burst advance, active low |
| gw_ni | input | 1 | Global write, active low |
| bwe_ni | input | 1 | Byte write enable, active low |
| bsel_ni | input | NB | Per-lane write select, active low |
| oe_ni | input | 1 | Asynchronous output enable, active low |
| snooze_i | input | 1 | Snooze, active high |
| ilv_i | input | 1 | Burst order: 1 XOR, 0 add |
| data_i | input | NB*LW | Write data |
| data_o | output | NB*LW | Read data, zero when not driven |
| drive_o | output | 1 | Bus drive enable (low means high impedance) |

## Verification
The assertions assume that `oe_ni`, `snooze_i` and `ilv_i` change only between clock edges, away from sampling. They also assume that no write reaches an address that a suspended read is holding. The bench drives every input 2 ns after a rising edge, so outputs settle before they are sampled. Its suspend checks use read cycles only, so the stable-data property is never exposed to a write.

// File: rtl/sbs_pkg.sv
package sbs_pkg;
  typedef enum logic [1:0] {CYC_DESEL, CYC_BEGIN, CYC_CONT, CYC_HOLD} cyc_e;

  function automatic logic [1:0] burst_low(input logic [1:0] base,
                                           input logic [1:0] cnt,
                                           input logic       ilv);
    return ilv ? (base ^ cnt) : (base + cnt);
  endfunction
endpackage

// File: rtl/sbs_decode.sv
module sbs_decode
  import sbs_pkg::*;
#(
  parameter int NB = 4
) (
  input  logic          proc_stb_ni,
  input  logic          ctrl_stb_ni,
  input  logic          en_main_ni,
  input  logic          en_hi_i,
  input  logic          en_lo_ni,
  input  logic          adv_ni,
  input  logic          gw_ni,
  input  logic          bwe_ni,
  input  logic [NB-1:0] bsel_ni,
  output cyc_e          cyc_o,
  output logic          wr_o,
  output logic [NB-1:0] wmask_o
);
  logic en_all, any_stb, wr_req, proc_begin;
  logic [NB-1:0] mask;

  assign en_all  = !en_main_ni && en_hi_i && !en_lo_ni;
  assign any_stb = !proc_stb_ni || !ctrl_stb_ni;

  always_comb begin
    if (en_main_ni && !ctrl_stb_ni)         cyc_o = CYC_DESEL;
    else if (!en_main_ni && !en_all && any_stb) cyc_o = CYC_DESEL;
    else if (en_all && any_stb)             cyc_o = CYC_BEGIN;
    else if (!adv_ni)                       cyc_o = CYC_CONT;
    else                                    cyc_o = CYC_HOLD;
  end

  assign wr_req     = !gw_ni || !bwe_ni;
  assign mask       = !gw_ni ? {NB{1'b1}} : (!bwe_ni ? ~bsel_ni : '0);
  // processor-opened bursts are reads regardless of write controls
  assign proc_begin = (cyc_o == CYC_BEGIN) && !proc_stb_ni;
  assign wr_o       = (cyc_o != CYC_DESEL) && !proc_begin && wr_req;
  assign wmask_o    = wr_o ? mask : '0;
endmodule

// File: rtl/sbs_burst_addr.sv
module sbs_burst_addr
  import sbs_pkg::*;
#(
  parameter int AW = 6
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          step_en_i,
  input  cyc_e          cyc_i,
  input  logic [AW-1:0] addr_i,
  input  logic          ilv_i,
  output logic [AW-1:0] addr_nxt_o,
  output logic [AW-1:0] addr_q_o
);
  logic [AW-3:0] hi_q, hi_n;
  logic [1:0]    lo_q, lo_n, cnt_q, cnt_n;

  always_comb begin
    hi_n  = hi_q;
    lo_n  = lo_q;
    cnt_n = cnt_q;
    unique case (cyc_i)
      CYC_BEGIN: begin
        hi_n  = addr_i[AW-1:2];
        lo_n  = addr_i[1:0];
        cnt_n = 2'd0;
      end
      CYC_CONT: cnt_n = cnt_q + 2'd1;
      default:  ;
    endcase
  end

  assign addr_nxt_o = {hi_n, burst_low(lo_n, cnt_n, ilv_i)};
  assign addr_q_o   = {hi_q, burst_low(lo_q, cnt_q, ilv_i)};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_q  <= '0;
      lo_q  <= '0;
      cnt_q <= '0;
    end else if (step_en_i) begin
      hi_q  <= hi_n;
      lo_q  <= lo_n;
      cnt_q <= cnt_n;
    end
  end
endmodule

// File: rtl/sbs_array.sv
module sbs_array #(
  parameter int AW = 6,
  parameter int NB = 4,
  parameter int LW = 9,
  localparam int DEPTH = 1 << AW,
  localparam int DW = NB * LW
) (
  input  logic          clk_i,
  input  logic [NB-1:0] we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  for (genvar g = 0; g < NB; g++) begin : g_lane
    logic [LW-1:0] lane_mem [DEPTH];
    always_ff @(posedge clk_i) begin
      if (we_i[g]) lane_mem[waddr_i] <= wdata_i[g*LW +: LW];
    end
    assign rdata_o[g*LW +: LW] = lane_mem[raddr_i];
  end
endmodule

// File: rtl/sync_burst_sram.sv
module sync_burst_sram
  import sbs_pkg::*;
#(
  parameter int AW = 6,
  parameter int NB = 4,
  parameter int LW = 9,
  localparam int DW = NB * LW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] addr_i,
  input  logic          proc_stb_ni,
  input  logic          ctrl_stb_ni,
  input  logic          en_main_ni,
  input  logic          en_hi_i,
  input  logic          en_lo_ni,
  input  logic          adv_ni,
  input  logic          gw_ni,
  input  logic          bwe_ni,
  input  logic [NB-1:0] bsel_ni,
  input  logic          oe_ni,
  input  logic          snooze_i,
  input  logic          ilv_i,
  input  logic [DW-1:0] data_i,
  output logic [DW-1:0] data_o,
  output logic          drive_o
);
  cyc_e          cyc;
  logic          wr;
  logic [NB-1:0] wmask;
  logic [AW-1:0] addr_nxt, addr_q;
  logic [DW-1:0] rdata;
  logic          sel_q, wr_q;

  sbs_decode #(.NB(NB)) u_decode (
    .proc_stb_ni, .ctrl_stb_ni, .en_main_ni, .en_hi_i, .en_lo_ni,
    .adv_ni, .gw_ni, .bwe_ni, .bsel_ni,
    .cyc_o(cyc), .wr_o(wr), .wmask_o(wmask)
  );

  sbs_burst_addr #(.AW(AW)) u_addr (
    .clk_i, .rst_ni,
    .step_en_i (!snooze_i),
    .cyc_i     (cyc),
    .addr_i,
    .ilv_i,
    .addr_nxt_o(addr_nxt),
    .addr_q_o  (addr_q)
  );

  sbs_array #(.AW(AW), .NB(NB), .LW(LW)) u_array (
    .clk_i,
    .we_i   (snooze_i ? '0 : wmask),
    .waddr_i(addr_nxt),
    .wdata_i(data_i),
    .raddr_i(addr_q),
    .rdata_o(rdata)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q <= 1'b0;
      wr_q  <= 1'b0;
    end else if (!snooze_i) begin
      if (cyc == CYC_DESEL)      sel_q <= 1'b0;
      else if (cyc == CYC_BEGIN) sel_q <= 1'b1;
      wr_q <= wr;
    end
  end

  assign drive_o = sel_q && !wr_q && !oe_ni && !snooze_i;
  assign data_o  = drive_o ? rdata : '0;
endmodule

// File: rtl/sync_burst_sram_chk.sv
module sync_burst_sram_chk #(
  parameter int AW = 6,
  parameter int NB = 4,
  parameter int LW = 9,
  localparam int DW = NB * LW
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          proc_stb_ni,
  input logic          ctrl_stb_ni,
  input logic          en_main_ni,
  input logic          en_hi_i,
  input logic          en_lo_ni,
  input logic          adv_ni,
  input logic          gw_ni,
  input logic          bwe_ni,
  input logic          oe_ni,
  input logic          snooze_i,
  input logic [DW-1:0] data_o,
  input logic          drive_o
);
  // R1
  desel_main_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!snooze_i && en_main_ni && !ctrl_stb_ni) |=> !drive_o);

  // R2
  desel_sec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!snooze_i && !en_main_ni && (!en_hi_i || en_lo_ni) &&
     (!proc_stb_ni || !ctrl_stb_ni)) |=> !drive_o);

  // R3
  proc_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!snooze_i && !en_main_ni && en_hi_i && !en_lo_ni && !proc_stb_ni)
    |=> (oe_ni || snooze_i || drive_o));

  // R4
  ctrl_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!snooze_i && !en_main_ni && en_hi_i && !en_lo_ni && proc_stb_ni &&
     !ctrl_stb_ni && (!gw_ni || !bwe_ni)) |=> !drive_o);

  // R6
  hold_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!snooze_i && proc_stb_ni && ctrl_stb_ni && adv_ni && gw_ni && bwe_ni &&
     drive_o) |=> (!drive_o || $stable(data_o)));

  // R12
  snooze_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snooze_i |-> !drive_o);
endmodule

bind sync_burst_sram sync_burst_sram_chk #(.AW(AW), .NB(NB), .LW(LW)) u_chk (.*);

// File: tb/sync_burst_sram_bench.sv
module sync_burst_sram_bench;
  localparam int AW = 6, NB = 4, LW = 9, DW = NB * LW;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic [AW-1:0] addr_i;
  logic proc_stb_ni, ctrl_stb_ni, en_main_ni, en_hi_i, en_lo_ni, adv_ni;
  logic gw_ni, bwe_ni, oe_ni, snooze_i, ilv_i;
  logic [NB-1:0] bsel_ni;
  logic [DW-1:0] data_i, data_o;
  logic drive_o;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [DW-1:0] ref_mem [1 << AW];

  always #5 clk_i = ~clk_i;

  sync_burst_sram #(.AW(AW), .NB(NB), .LW(LW)) u_sync_burst_sram (.*);

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic chk_rd(input string req, input logic [AW-1:0] a);
    chk(req, {{(DW-1){1'b0}}, drive_o}, 1);
    chk(req, data_o, ref_mem[a]);
  endtask

  task automatic chk_off(input string req);
    chk(req, {{(DW-1){1'b0}}, drive_o}, 0);
    chk(req, data_o, 0);
  endtask

  function automatic logic [AW-1:0] seq_addr(input logic [AW-1:0] b, input int n, input bit il);
    logic [1:0] s = 2'(n);
    return {b[AW-1:2], il ? (b[1:0] ^ s) : (b[1:0] + s)};
  endfunction

  function automatic logic [DW-1:0] merge(input logic [DW-1:0] old, input logic [DW-1:0] d,
                                          input logic [NB-1:0] m);
    logic [DW-1:0] r = old;
    for (int i = 0; i < NB; i++) if (m[i]) r[i*LW +: LW] = d[i*LW +: LW];
    return r;
  endfunction

  task automatic tick(); @(posedge clk_i); #2; endtask

  task automatic idle();
    proc_stb_ni = 1; ctrl_stb_ni = 1; en_main_ni = 0; en_hi_i = 1; en_lo_ni = 0;
    adv_ni = 1; gw_ni = 1; bwe_ni = 1; bsel_ni = '1; oe_ni = 0; snooze_i = 0;
    data_i = '0;
  endtask

  task automatic go_proc(input logic [AW-1:0] a);
    addr_i = a; proc_stb_ni = 0; tick(); proc_stb_ni = 1;
  endtask

  task automatic go_ctrl(input logic [AW-1:0] a);
    addr_i = a; ctrl_stb_ni = 0; tick(); ctrl_stb_ni = 1;
  endtask

  task automatic go_cont(); adv_ni = 0; tick(); adv_ni = 1; endtask

  task automatic t_reset();
    tick();
    chk_off("R13 reset");
  endtask

  task automatic t_burst_write();
    ilv_i = 0; gw_ni = 0;
    data_i = 36'h100; go_ctrl(6'd8);
    chk_off("R4 write begin");
    ref_mem[8] = 36'h100;
    for (int n = 1; n < 4; n++) begin
      data_i = 36'h100 + DW'(n); go_cont();
      ref_mem[seq_addr(6'd8, n, 0)] = 36'h100 + DW'(n);
      chk_off("R10 write cont");
    end
    ilv_i = 1;
    data_i = 36'h200; go_ctrl(6'd13);
    ref_mem[13] = 36'h200;
    for (int n = 1; n < 4; n++) begin
      data_i = 36'h200 + DW'(n); go_cont();
      ref_mem[seq_addr(6'd13, n, 1)] = 36'h200 + DW'(n);
    end
    idle();
  endtask

  task automatic t_proc_read();
    ilv_i = 0; gw_ni = 0; data_i = 36'hDEAD;
    go_proc(6'd9);
    gw_ni = 1;
    chk(" R3 proc read ignores write", data_o, 36'h101);
    for (int n = 1; n < 4; n++) begin
      go_cont();
      chk_rd("R5 linear", seq_addr(6'd9, n, 0));
    end
    ilv_i = 1;
    go_proc(6'd13);
    chk_rd("R3 begin", 6'd13);
    for (int n = 1; n < 4; n++) begin
      go_cont();
      chk(" R5 interleave", data_o, 36'h200 + DW'(n));
    end
    idle();
  endtask

  task automatic t_suspend_oe();
    ilv_i = 0;
    go_proc(6'd10);
    tick(); chk_rd("R6 hold", 6'd10);
    tick(); chk_rd("R6 hold", 6'd10);
    go_cont(); chk_rd("R6 then cont", 6'd11);
    oe_ni = 1; #1; chk_off("R10 oe high");
    oe_ni = 0; #1; chk_rd("R11 async oe", 6'd11);
  endtask

  task automatic t_bytes();
    gw_ni = 1; bwe_ni = 0; bsel_ni = 4'b1010; data_i = {4{9'h1AB}};
    go_ctrl(6'd9);
    chk_off("R8 byte write");
    ref_mem[9] = merge(ref_mem[9], {4{9'h1AB}}, 4'b0101);
    idle();
    go_proc(6'd9); chk_rd("R8 lanes", 6'd9);
    data_i = 36'hFFF; go_ctrl(6'd11);
    chk_rd("R9 ctrl read", 6'd11);
    go_proc(6'd11); chk_rd("R9 no change", 6'd11);
    idle();
  endtask

  task automatic t_deselect();
    go_proc(6'd8);
    en_main_ni = 1; gw_ni = 0; data_i = 36'h777;
    go_ctrl(6'd8);
    chk_off("R1 deselect");
    idle(); tick(); chk_off("R1 stays off");
    go_proc(6'd8); chk_rd("R1 no write", 6'd8);
    en_hi_i = 0; gw_ni = 0; data_i = 36'h555;
    go_ctrl(6'd10);
    chk_off("R2 hi enable low");
    idle();
    go_proc(6'd10); chk_rd("R2 no write", 6'd10);
    en_lo_ni = 1; go_proc(6'd12);
    chk_off("R2 lo enable high");
    idle();
  endtask

  task automatic t_ignore_proc();
    ilv_i = 0;
    go_proc(6'd12);
    en_main_ni = 1; adv_ni = 0; addr_i = 6'd0; proc_stb_ni = 0;
    tick();
    chk_rd("R7 continue", 6'd13);
    adv_ni = 1; tick();
    chk_rd("R7 suspend", 6'd13);
    idle();
  endtask

  task automatic t_snooze();
    go_proc(6'd14);
    chk_rd("R12 before", 6'd14);
    snooze_i = 1; gw_ni = 0; data_i = 36'h999; adv_ni = 0;
    go_ctrl(6'd14);
    chk_off("R12 snoozing");
    tick();
    chk_off("R12 snoozing");
    idle(); #1;
    chk_rd("R12 resumes", 6'd14);
    tick();
    go_proc(6'd14); chk_rd("R12 no write", 6'd14);
  endtask

  initial begin
    idle(); ilv_i = 0; addr_i = '0;
    #12 rst_ni = 1;
    t_reset();
    t_burst_write();
    t_proc_read();
    t_suspend_oe();
    t_bytes();
    t_deselect();
    t_ignore_proc();
    t_snooze();
    done = 1;
    summary();
  end

  initial begin
    #2000000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog act=running exp=done");
      summary();
    end
  end
endmodule